// File: doc/BRIEF.md
# Host Shared-Memory Mailbox Port

This block is the host side of an I/O coprocessor. The host sees a small window: five offset bits and a byte-wide data bus. Through that window it can move a 16-bit pointer into the coprocessor's RAM, read or write the RAM byte at the pointer, read and write a control/status byte, and, in bypass mode only, reach the registers of a peripheral device directly. The RAM sits outside the block behind a synchronous port, and its read data arrives one cycle after the request. All host read responses therefore come back one cycle after the request, marked by a valid strobe.

The status byte links the two processors in both directions. The host can ring the coprocessor's doorbell (a one-cycle pulse that feeds the coprocessor's host interrupt source). It can also hold the coprocessor core in reset and enable pointer auto-increment. The coprocessor raises one or both host flags through its own host register, and those flags drive the host interrupt line until the host writes ones to clear them. A peripheral interrupt input is mirrored into the status byte. The way the status byte reads back depends on the bypass mode. The peripheral register port is shared: in bypass mode the host owns it, and otherwise the coprocessor owns it.

Top module: `mbx_host_port`

## Requirements
- R1: Offset decode follows a fixed priority. Bit 4 set selects the device window, with bits 3:0 as the register index. Otherwise bit 2 selects the RAM data port, then bit 1 selects status, then bit 0 selects pointer low. Every other offset selects pointer high. Example: offset 0x08 reaches pointer high, and offset 0x17 reaches device register 7.
- R2: A RAM data access uses the current pointer on `ram_addr`. After the access, the pointer advances by one only while status bit 1 is set. It wraps from 0xFFFF to 0x0000.
- R3: Each host read raises `host_rvalid` for one cycle, one cycle after the request, with `host_rdata` valid in that cycle. For the RAM port, that data is the RAM's read data.
- R4: A host status write stores data bits 2:1 into status bits 2:1. It clears status bits 3 and 0 and keeps bits 7:4, apart from the flag clearing in R7. `core_rst_n` follows status bit 2, so 0 holds the core in reset.
- R5: A status read in bypass mode returns the status byte with bit 0 forced to 1. In normal mode it returns the status with bit 7 forced to 1 and bit 6 forced to 0.
- R6: A host status write with data bit 3 set produces a one-cycle `cp_doorbell` pulse in the following cycle.
- R7: A host status write with data bit 4 or bit 5 set clears the matching host flag (status bits 4 and 5). `host_irq` is high exactly while either flag is set.
- R8: A coprocessor host-register write ORs data bits 3:2 into status bits 5:4, which raises `host_irq` if either bit is 1. `cp_hreg_rdata` returns status bits 5:4 in bits 3:2, with the other bits 0.
- R9: Status bit 6 follows `periph_irq` with one cycle of delay.
- R10: Host device-window accesses reach the device port only in bypass mode, and they read 0 otherwise. Coprocessor device accesses reach it only outside bypass mode, and `cp_dev_rdata` reads 0 in bypass mode.
- R11: After `rst_n` the status byte is 0x80. A `soft_rst` cycle ANDs it with 0xC3, which drops `host_irq` and `core_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous block reset, active high |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | Host access is a write |
| host_addr | input | OFS_W | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response strobe |
| host_irq | output | 1 | Host interrupt line |
| bypass | input | 1 | Bypass mode select |
| periph_irq | input | 1 | Peripheral interrupt level |
| core_rst_n | output | 1 | Coprocessor core reset, active low |
| cp_doorbell | output | 1 | Pulse to the coprocessor's host interrupt source |
| cp_hreg_wr | input | 1 | Coprocessor write to its host register |
| cp_hreg_wdata | input | 8 | Coprocessor host register write data |
| cp_hreg_rdata | output | 8 | Coprocessor host register read data |
| cp_dev_req | input | 1 | Coprocessor device register access strobe |
| cp_dev_wr | input | 1 | Coprocessor device access is a write |
| cp_dev_idx | input | 4 | Coprocessor device register index |
| cp_dev_wdata | input | 8 | Coprocessor device write data |
| cp_dev_rdata | output | 8 | Coprocessor device read data |
| dev_req | output | 1 | Device port access strobe |
| dev_wr | output | 1 | Device port write |
| dev_idx | output | 4 | Device port register index |
| dev_wdata | output | 8 | Device port write data |
| dev_rdata | input | 8 | Device port read data, same cycle |
| ram_req | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | PTR_W | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_req |

## Verification
The assertions assume that each host access is a single-cycle strobe with no overlapping access. They also assume that the device port returns read data in the same cycle and the RAM one cycle later. `bypass` is treated as a quasi-static mode that does not change around an access. The bench meets these assumptions: it drives every input at the falling edge, issues one access per task call, and changes `bypass` and `periph_irq` only between accesses with an idle cycle in between. The bench's RAM model is a synchronous byte array indexed by the low address byte, and its device model returns 0xA0 plus the index and logs each write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [2:0] {
      WIN_DEV,
      WIN_RAM,
      WIN_STAT,
      WIN_PLO,
      WIN_PHI
   } mbx_win_e;

   localparam logic [7:0] STAT_POWERUP = 8'h80;
   localparam logic [7:0] STAT_SOFTKEEP = 8'hC3;
   localparam int unsigned DEV_IDX_W = 4;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
   import mbx_pkg::*;
#(
   parameter int unsigned OFS_W = 5
) (
   input  logic [OFS_W-1:0]     addr,
   output mbx_win_e             win,
   output logic [DEV_IDX_W-1:0] idx
);
   always_comb begin
      if (addr[4])      win = WIN_DEV;
      else if (addr[2]) win = WIN_RAM;
      else if (addr[1]) win = WIN_STAT;
      else if (addr[0]) win = WIN_PLO;
      else              win = WIN_PHI;
   end

   assign idx = addr[DEV_IDX_W-1:0];
endmodule

// File: rtl/mbx_pointer.sv
module mbx_pointer #(
   parameter int unsigned PTR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   input  logic             inc,
   output logic [PTR_W-1:0] ptr
);
   localparam int unsigned HI_W = PTR_W - 8;

   logic [PTR_W-1:0] one;
   assign one = {{(PTR_W-1){1'b0}}, 1'b1};

   logic [7:0] unused_hi_bits;

   generate
      if (HI_W < 8) begin : g_narrow
         assign unused_hi_bits = {wdata[7:HI_W], {HI_W{1'b0}}};
      end else begin : g_full
         assign unused_hi_bits = 8'h00;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (wr_lo) begin
         ptr[7:0] <= wdata;
      end else if (wr_hi) begin
         ptr[PTR_W-1:8] <= wdata[HI_W-1:0];
      end else if (inc) begin
         ptr <= ptr + one;
      end
   end
endmodule

// File: rtl/mbx_status.sv
module mbx_status
   import mbx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       host_wr,
   input  logic [7:0] host_data,
   input  logic       cp_wr,
   input  logic [1:0] cp_flags,
   input  logic       periph_irq,
   output logic [7:0] status,
   output logic       doorbell,
   output logic       irq
);
   logic [7:0] nxt;
   logic unused_data;
   assign unused_data = ^{host_data[7:6], host_data[0]};

   always_comb begin
      nxt = status;
      nxt[6] = periph_irq;
      if (host_wr) begin
         nxt[5:4] = status[5:4] & ~host_data[5:4];
         nxt[3] = 1'b0;
         nxt[2:1] = host_data[2:1];
         nxt[0] = 1'b0;
      end
      if (cp_wr) begin
         nxt[5:4] = nxt[5:4] | cp_flags;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status   <= STAT_POWERUP;
         doorbell <= 1'b0;
      end else begin
         doorbell <= host_wr & host_data[3];
         if (soft_rst) status <= status & STAT_SOFTKEEP;
         else          status <= nxt;
      end
   end

   assign irq = |status[5:4];
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
   import mbx_pkg::*;
#(
   parameter int unsigned PTR_W = 16,
   parameter int unsigned OFS_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             host_req,
   input  logic             host_wr,
   input  logic [OFS_W-1:0] host_addr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   output logic             host_rvalid,
   output logic             host_irq,
   input  logic             bypass,
   input  logic             periph_irq,
   output logic             core_rst_n,
   output logic             cp_doorbell,
   input  logic             cp_hreg_wr,
   input  logic [7:0]       cp_hreg_wdata,
   output logic [7:0]       cp_hreg_rdata,
   input  logic             cp_dev_req,
   input  logic             cp_dev_wr,
   input  logic [3:0]       cp_dev_idx,
   input  logic [7:0]       cp_dev_wdata,
   output logic [7:0]       cp_dev_rdata,
   output logic             dev_req,
   output logic             dev_wr,
   output logic [3:0]       dev_idx,
   output logic [7:0]       dev_wdata,
   input  logic [7:0]       dev_rdata,
   output logic             ram_req,
   output logic             ram_we,
   output logic [PTR_W-1:0] ram_addr,
   output logic [7:0]       ram_wdata,
   input  logic [7:0]       ram_rdata
);
   generate
      if (PTR_W < 9 || PTR_W > 16) begin : g_bad_ptr
         $error("mbx_host_port: PTR_W must be 9..16");
      end
      if (OFS_W < 5) begin : g_bad_ofs
         $error("mbx_host_port: OFS_W must be at least 5");
      end
   endgenerate

   mbx_win_e             win;
   logic [DEV_IDX_W-1:0] hidx;
   logic [7:0]           status_q;
   logic [PTR_W-1:0]     ptr_q;
   logic                 stat_wr, host_dev, cp_dev, rd;
   logic                 from_ram_q;
   logic [7:0]           rsp_q, rsp_d, ptr_hi8;
   logic [1:0]           unused_cp_bits;
   assign unused_cp_bits = {^cp_hreg_wdata[7:4], ^cp_hreg_wdata[1:0]};

   mbx_decode #(.OFS_W(OFS_W)) u_dec (
      .addr(host_addr), .win(win), .idx(hidx)
   );

   assign ram_req   = host_req && (win == WIN_RAM);
   assign ram_we    = host_wr;
   assign ram_addr  = ptr_q;
   assign ram_wdata = host_wdata;
   assign stat_wr   = host_req && host_wr && (win == WIN_STAT);
   assign rd        = host_req && !host_wr;

   mbx_pointer #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(host_req && host_wr && (win == WIN_PLO)),
      .wr_hi(host_req && host_wr && (win == WIN_PHI)),
      .wdata(host_wdata),
      .inc(ram_req && status_q[1]),
      .ptr(ptr_q)
   );

   mbx_status u_stat (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .host_wr(stat_wr), .host_data(host_wdata),
      .cp_wr(cp_hreg_wr), .cp_flags(cp_hreg_wdata[3:2]),
      .periph_irq(periph_irq),
      .status(status_q), .doorbell(cp_doorbell), .irq(host_irq)
   );

   assign core_rst_n    = status_q[2];
   assign cp_hreg_rdata = {4'h0, status_q[5:4], 2'b00};

   // Shared device port: the mode decides which side owns it.
   assign host_dev     = host_req && (win == WIN_DEV) && bypass;
   assign cp_dev       = cp_dev_req && !bypass;
   assign dev_req      = host_dev || cp_dev;
   assign dev_wr       = host_dev ? host_wr    : cp_dev_wr;
   assign dev_idx      = host_dev ? hidx       : cp_dev_idx;
   assign dev_wdata    = host_dev ? host_wdata : cp_dev_wdata;
   assign cp_dev_rdata = cp_dev ? dev_rdata : 8'h00;

   generate
      if (PTR_W < 16) begin : g_hi_pad
         assign ptr_hi8 = {{(16-PTR_W){1'b0}}, ptr_q[PTR_W-1:8]};
      end else begin : g_hi_full
         assign ptr_hi8 = ptr_q[15:8];
      end
   endgenerate

   always_comb begin
      case (win)
         WIN_DEV:  rsp_d = bypass ? dev_rdata : 8'h00;
         WIN_STAT: rsp_d = bypass ? (status_q | 8'h01)
                                  : {2'b10, status_q[5:0]};
         WIN_PLO:  rsp_d = ptr_q[7:0];
         WIN_PHI:  rsp_d = ptr_hi8;
         default:  rsp_d = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rvalid <= 1'b0;
         from_ram_q  <= 1'b0;
         rsp_q       <= 8'h00;
      end else begin
         host_rvalid <= rd;
         from_ram_q  <= rd && (win == WIN_RAM);
         if (rd) rsp_q <= rsp_d;
      end
   end

   assign host_rdata = from_ram_q ? ram_rdata : rsp_q;
endmodule

// File: rtl/mbx_host_port_chk.sv
module mbx_host_port_chk #(
   parameter int unsigned PTR_W = 16,
   parameter int unsigned OFS_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             host_req,
   input logic             host_wr,
   input logic [OFS_W-1:0] host_addr,
   input logic [7:0]       host_wdata,
   input logic             host_rvalid,
   input logic             host_irq,
   input logic             core_rst_n,
   input logic             cp_doorbell,
   input logic             cp_hreg_wr,
   input logic [7:0]       cp_hreg_wdata,
   input logic             periph_irq,
   input logic             bypass,
   input logic             dev_req,
   input logic             cp_dev_req,
   input logic             ram_req,
   input logic [PTR_W-1:0] ram_addr,
   input logic [7:0]       status_q,
   input logic [PTR_W-1:0] ptr_q
);
   logic swr;
   assign swr = host_req && host_wr && !host_addr[4] && !host_addr[2] && host_addr[1];

   p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req |=> ptr_q == PTR_W'($past(ram_addr)
                  + {{(PTR_W-1){1'b0}}, $past(status_q[1])}));

   p_rsp_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_wr) |=> host_rvalid);

   p_core_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (swr && !soft_rst) |=> core_rst_n == $past(host_wdata[2]));

   p_doorbell_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (swr && host_wdata[3]) |=> cp_doorbell);

   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (swr && host_wdata[5:4] == 2'b11 && !cp_hreg_wr && !soft_rst) |=> !host_irq);

   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_hreg_wr && |cp_hreg_wdata[3:2] && !soft_rst) |=> host_irq);

   p_periph_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst |=> status_q[6] == $past(periph_irq));

   p_dev_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req && bypass) |-> (host_req && host_addr[4]));

   p_dev_cp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req && !bypass) |-> cp_dev_req);

   p_soft_r11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!host_irq && !core_rst_n));
endmodule

bind mbx_host_port mbx_host_port_chk #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/mbx_host_port_test.sv
module mbx_host_port_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0;
   logic host_req = 1'b0, host_wr = 1'b0;
   logic [4:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic host_rvalid, host_irq, core_rst_n, cp_doorbell;
   logic bypass = 1'b0, periph_irq = 1'b0;
   logic cp_hreg_wr = 1'b0;
   logic [7:0] cp_hreg_wdata = '0, cp_hreg_rdata;
   logic cp_dev_req = 1'b0, cp_dev_wr = 1'b0;
   logic [3:0] cp_dev_idx = '0;
   logic [7:0] cp_dev_wdata = '0, cp_dev_rdata;
   logic dev_req, dev_wr;
   logic [3:0] dev_idx;
   logic [7:0] dev_wdata, dev_rdata;
   logic ram_req, ram_we;
   logic [15:0] ram_addr;
   logic [7:0] ram_wdata;
   logic [7:0] ram_rdata = '0;

   int checks = 0, fails = 0;
   logic [7:0] mem [256];
   int dev_wr_cnt = 0;
   logic [3:0] dev_last_idx = '0;
   logic [7:0] dev_last_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_host_port uut (.*);

   assign dev_rdata = {4'hA, dev_idx};

   always @(posedge clk) begin
      if (ram_req) begin
         if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
         ram_rdata <= mem[ram_addr[7:0]];
      end
      if (dev_req && dev_wr) begin
         dev_wr_cnt <= dev_wr_cnt + 1;
         dev_last_idx <= dev_idx;
         dev_last_data <= dev_wdata;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic host_acc(input logic wr, input logic [4:0] a,
                           input logic [7:0] d, output logic [7:0] q);
      @(negedge clk);
      host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_req = 1'b0; host_wr = 1'b0;
      if (!wr) check("R3 rvalid", int'(host_rvalid), 1);
      q = host_rdata;
   endtask

   task automatic cp_write(input logic [7:0] d);
      @(negedge clk);
      cp_hreg_wr = 1'b1; cp_hreg_wdata = d;
      @(negedge clk);
      cp_hreg_wr = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] q;
      int cnt0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R11 power-up state
      check("R11 irq after reset", int'(host_irq), 0);
      check("R11 core held", int'(core_rst_n), 0);
      host_acc(1'b0, 5'h02, 8'h00, q);
      check("R5 R11 normal status", int'(q), 'h80);
      bypass = 1'b1; idle();
      host_acc(1'b0, 5'h02, 8'h00, q);
      check("R5 bypass status", int'(q), 'h81);
      bypass = 1'b0; idle();

      // R1 decode of pointer bytes
      host_acc(1'b1, 5'h00, 8'h12, q);
      host_acc(1'b1, 5'h01, 8'h34, q);
      host_acc(1'b0, 5'h01, 8'h00, q);
      check("R1 ptr lo", int'(q), 'h34);
      host_acc(1'b0, 5'h08, 8'h00, q);
      check("R1 offset 8 is ptr hi", int'(q), 'h12);
      host_acc(1'b0, 5'h0B, 8'h00, q);
      check("R1 offset 0xB is status", int'(q), 'h80);

      // R4 status write releases the core and enables auto-increment
      host_acc(1'b1, 5'h02, 8'h06, q);
      check("R4 core released", int'(core_rst_n), 1);
      host_acc(1'b0, 5'h02, 8'h00, q);
      check("R4 status stored", int'(q), 'h86);

      // R2 R3 RAM write sweep with auto-increment
      host_acc(1'b1, 5'h00, 8'h00, q);
      host_acc(1'b1, 5'h01, 8'h10, q);
      for (int i = 0; i < 8; i++) host_acc(1'b1, 5'h04, 8'((i*7+3) & 255), q);
      host_acc(1'b0, 5'h01, 8'h00, q);
      check("R2 ptr after writes", int'(q), 'h18);
      host_acc(1'b1, 5'h01, 8'h10, q);
      for (int i = 0; i < 8; i++) begin
         host_acc(1'b0, 5'h0C, 8'h00, q);
         check("R2 R3 ram read", int'(q), (i*7+3) & 255);
      end

      // R2 no increment while bit 1 clear
      host_acc(1'b1, 5'h02, 8'h04, q);
      host_acc(1'b1, 5'h04, 8'h99, q);
      host_acc(1'b0, 5'h01, 8'h00, q);
      check("R2 no increment", int'(q), 'h18);
      host_acc(1'b1, 5'h02, 8'h06, q);

      // R2 wrap
      host_acc(1'b1, 5'h00, 8'hFF, q);
      host_acc(1'b1, 5'h01, 8'hFF, q);
      host_acc(1'b1, 5'h04, 8'h5C, q);
      host_acc(1'b0, 5'h00, 8'h00, q);
      check("R2 wrap hi", int'(q), 0);
      host_acc(1'b0, 5'h01, 8'h00, q);
      check("R2 wrap lo", int'(q), 0);

      // R6 doorbell pulse
      host_acc(1'b1, 5'h02, 8'h0E, q);
      check("R6 doorbell high", int'(cp_doorbell), 1);
      idle();
      check("R6 doorbell one cycle", int'(cp_doorbell), 0);

      // R8 coprocessor sets flags
      cp_write(8'h04);
      check("R8 irq raised", int'(host_irq), 1);
      check("R8 cp read", int'(cp_hreg_rdata), 'h04);
      host_acc(1'b0, 5'h02, 8'h00, q);
      check("R8 status flag", int'(q), 'h96);
      cp_write(8'h08);
      check("R8 both flags", int'(cp_hreg_rdata), 'h0C);

      // R7 write-one-to-clear
      host_acc(1'b1, 5'h02, 8'h16, q);
      check("R7 one flag left irq", int'(host_irq), 1);
      check("R7 flag bit 4 cleared", int'(cp_hreg_rdata), 'h08);
      host_acc(1'b1, 5'h02, 8'h26, q);
      check("R7 irq cleared", int'(host_irq), 0);

      // R9 R5 peripheral interrupt mirror
      periph_irq = 1'b1; idle();
      host_acc(1'b0, 5'h02, 8'h00, q);
      check("R9 R5 normal hides bit 6", int'(q), 'h86);
      bypass = 1'b1; idle();
      host_acc(1'b0, 5'h02, 8'h00, q);
      check("R9 bypass shows bit 6", int'(q), 'hC7);
      periph_irq = 1'b0; idle();
      host_acc(1'b0, 5'h02, 8'h00, q);
      check("R9 bit 6 cleared", int'(q), 'h87);
      bypass = 1'b0; idle();

      // R10 device window gating
      cnt0 = dev_wr_cnt;
      host_acc(1'b0, 5'h13, 8'h00, q);
      check("R10 host dev read normal", int'(q), 0);
      host_acc(1'b1, 5'h15, 8'h77, q);
      check("R10 host dev write dropped", dev_wr_cnt, cnt0);
      @(negedge clk);
      cp_dev_req = 1'b1; cp_dev_wr = 1'b0; cp_dev_idx = 4'h5;
      #1 check("R10 cp dev read normal", int'(cp_dev_rdata), 'hA5);
      bypass = 1'b1;
      #1 check("R10 cp dev read bypass", int'(cp_dev_rdata), 0);
      cp_dev_req = 1'b0;
      host_acc(1'b1, 5'h12, 8'h5A, q);
      check("R10 host dev write count", dev_wr_cnt, cnt0 + 1);
      check("R10 host dev write data", int'({dev_last_idx, dev_last_data}), 'h25A);
      host_acc(1'b0, 5'h17, 8'h00, q);
      check("R1 R10 offset 0x17 dev read", int'(q), 'hA7);
      bypass = 1'b0; idle();

      // R11 soft reset
      cp_write(8'h04);
      check("R11 irq before soft reset", int'(host_irq), 1);
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      check("R11 irq dropped", int'(host_irq), 0);
      check("R11 core reset", int'(core_rst_n), 0);
      host_acc(1'b0, 5'h02, 8'h00, q);
      check("R11 status masked", int'(q), 'h82);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule